// File: doc/BRIEF.md
# SPI Node Register Decoder

This block is the receiving end of a shared slow-control SPI link on which one master reaches a single motherboard node and up to twenty-five front-end nodes. Every node sees the same clock, select and data lines. It recognises frames meant for it by a five-bit structure address that is compared against its own `node_id` pin. Address 0 is the motherboard and 1 to 25 are the front-end nodes. Address 31 is a broadcast write that reaches every front-end node at once.

A frame is 32 bits and is shifted in MSB first while chip select is low. It is acted on only when chip select rises after exactly 32 clock edges. A write updates one register. A read captures the register's value, and the node returns it on MISO during the next chip-select window. A front-end node has a control register, a mask register, a read-only status word taken from its pins, and a configuration-stream register. The configuration-stream register hands each accepted word to downstream logic over a valid/ready port. The motherboard has only control and a status word built from five health flags.

The SPI lines are sampled by the system clock, so each SPI half period must last at least four system clock periods. The configuration-stream output holds `cfg_valid` and `cfg_data` steady until `cfg_ready` is seen high at a clock edge. A new word is taken only if the slot is empty, or is being emptied at that same edge. Otherwise the new word is dropped, and there is no error signal. `node_id` must lie in 0..25 and may change only while reset is held.

Top module: `spi_node_decoder`

## Requirements
- R1: A frame is the 32 MOSI bits sampled on SCLK rising edges while CS_N is low, first bit into bit 31. It is committed when CS_N goes high after exactly 32 rising edges. The commit takes effect at the third rising clk edge after CS_N rises. A window with any other edge count changes no register.
- R2: Frame bit 31 is the direction, 1 for write and 0 for read. Bits 30..26 are the structure address, bits 25..21 the register offset and bits 15..0 the data. Bits 20..16 have no effect.
- R3: A node acts on a frame whose address equals `node_id`. A front-end node (id 1..25) also acts on writes to address 31. Frames with any other address have no effect.
- R4: The offsets are 0 control, 1 status, 2 mask and 3 configuration stream. The motherboard (id 0) has only offsets 0 and 1. Writes to any offset a node lacks are ignored, and reads of such an offset return 0.
- R5: Status is read-only and writes to it are ignored. On a front-end node it reads `fe_status`. On the motherboard it reads `mb_flags` in bits 15..11 (bit 15 test mode, 14 serial-link ready, 13 timing-receiver ready, 12 PLL error, 11 PLL lock), with bits 10..0 zero. The value is taken at commit time.
- R6: A committed read addressed to the node makes the next CS_N-low window drive `spi_miso_oe` high. In that window MISO shifts out, MSB first, the word {1'b0, address, offset, 5'b0, data}. Bit 31 is present from the start of the window and the output advances after each SCLK falling edge. Outside such a window `spi_miso_oe` and `spi_miso` are 0. Each response is offered in one window only.
- R7: A read to address 31 produces no response window.
- R8: A write to offset 3 on a front-end node raises `cfg_valid` with `cfg_data` equal to the written data. Both are held until a clk edge with `cfg_ready` high. A write that finds the slot full is dropped, unless the slot drains at the commit edge, in which case the new word is taken. Reading offset 3 returns the last accepted word.
- R9: `ctrl_q` and `mask_q` show the control and mask registers.
- R10: After reset every register and output is 0 and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| node_id | input | 5 | This node's structure address |
| spi_sclk | input | 1 | SPI clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from master |
| spi_miso | output | 1 | SPI data to master |
| spi_miso_oe | output | 1 | High while this node drives MISO |
| mb_flags | input | 5 | Motherboard health flags (test, link, timing, PLL error, PLL lock) |
| fe_status | input | 16 | Front-end status word |
| ctrl_q | output | 16 | Control register |
| mask_q | output | 16 | Mask register |
| cfg_valid | output | 1 | Configuration word available |
| cfg_ready | input | 1 | Downstream accepts configuration word |
| cfg_data | output | 16 | Configuration word |

## Verification
The two functions that can meet in one cycle are a commit of a configuration-stream write and the downstream handshake that empties the slot. The bench fills the slot with `cfg_ready` low. It then sends a second write and raises `cfg_ready` for exactly the commit edge, which is found by counting clk edges from the rise of CS_N. A correct design shows `cfg_valid` still high with the new data. A design that drops the word shows `cfg_valid` low, and one that ignores the handshake still shows the old word.

// File: rtl/spi_dec_pkg.sv
package spi_dec_pkg;

  localparam int FRAME_W  = 32;
  localparam int ADDR_W   = 5;
  localparam int OFF_W    = 5;
  localparam int DATA_W   = 16;
  localparam int FLAG_W   = 5;

  localparam int RW_BIT   = FRAME_W - 1;
  localparam int ADDR_LSB = RW_BIT - ADDR_W;
  localparam int OFF_LSB  = ADDR_LSB - OFF_W;
  localparam int GAP_W    = OFF_LSB - DATA_W;
  localparam int CNT_W    = $clog2(FRAME_W + 2);

  localparam logic [ADDR_W-1:0] MB_ADDR    = '0;
  localparam logic [ADDR_W-1:0] BCAST_ADDR = '1;
  localparam logic [ADDR_W-1:0] LAST_FE    = ADDR_W'(25);

  typedef enum logic [OFF_W-1:0] {
    OFF_CTRL = OFF_W'(0),
    OFF_STAT = OFF_W'(1),
    OFF_MASK = OFF_W'(2),
    OFF_CFG  = OFF_W'(3)
  } reg_off_e;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [OFF_W-1:0]  off;
    logic [GAP_W-1:0]  spare;
    logic [DATA_W-1:0] data;
  } frame_t;

  function automatic frame_t split_frame(input logic [FRAME_W-1:0] w);
    frame_t f;
    f.wr    = w[RW_BIT];
    f.addr  = w[RW_BIT-1 -: ADDR_W];
    f.off   = w[ADDR_LSB-1 -: OFF_W];
    f.spare = w[OFF_LSB-1 -: GAP_W];
    f.data  = w[DATA_W-1:0];
    return f;
  endfunction

endpackage

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_dec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               mosi,
  output logic [FRAME_W-1:0] frame_q,
  output logic               commit,
  output logic               cs_fall,
  output logic               cs_rise,
  output logic               sclk_fall
);

  localparam int SYNC_D = 3;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);

  logic [SYNC_D-1:0] sclk_p, cs_p;
  logic [SYNC_D-2:0] mosi_p;
  logic [CNT_W-1:0]  bit_cnt;
  logic              sclk_rise, cs_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[SYNC_D-2:0], sclk};
      cs_p   <= {cs_p[SYNC_D-2:0], cs_n};
      mosi_p <= {mosi_p[SYNC_D-3:0], mosi};
    end
  end

  assign sclk_rise = sclk_p[SYNC_D-2] & ~sclk_p[SYNC_D-1];
  assign sclk_fall = ~sclk_p[SYNC_D-2] & sclk_p[SYNC_D-1];
  assign cs_rise   = cs_p[SYNC_D-2] & ~cs_p[SYNC_D-1];
  assign cs_fall   = ~cs_p[SYNC_D-2] & cs_p[SYNC_D-1];
  assign cs_low    = ~cs_p[SYNC_D-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      bit_cnt <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
    end else if (cs_low && sclk_rise) begin
      frame_q <= {frame_q[FRAME_W-2:0], mosi_p[SYNC_D-2]};
      if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign commit = cs_rise && (bit_cnt == CNT_FULL);

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_dec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [FRAME_W-1:0] frame_w,
  input  logic [ADDR_W-1:0]  node_id,
  input  logic [FLAG_W-1:0]  mb_flags,
  input  logic [DATA_W-1:0]  fe_status,
  input  logic               cfg_ready,
  output logic [DATA_W-1:0]  ctrl_q,
  output logic [DATA_W-1:0]  mask_q,
  output logic               cfg_valid,
  output logic [DATA_W-1:0]  cfg_data,
  output logic               rsp_load,
  output logic [FRAME_W-1:0] rsp_word
);

  localparam int FLAG_PAD = DATA_W - FLAG_W;

  frame_t            fr;
  logic              is_mb, is_fe, hit_own, hit_bc, wr_en;
  logic              slot_free, cfg_take;
  logic [DATA_W-1:0] cfg_last, stat_word, rd_data;
  logic              spare_unused;

  assign fr           = split_frame(frame_w);
  assign spare_unused = ^fr.spare;

  assign is_mb   = (node_id == MB_ADDR);
  assign is_fe   = !is_mb && (node_id <= LAST_FE);
  assign hit_own = (fr.addr == node_id) && (node_id != BCAST_ADDR);
  assign hit_bc  = (fr.addr == BCAST_ADDR) && is_fe;
  assign wr_en   = commit && fr.wr && (hit_own || hit_bc);

  // Status word layout depends on the node's role.
  generate
    if (FLAG_PAD > 0) begin : g_pad
      assign stat_word = is_mb ? {mb_flags, {FLAG_PAD{1'b0}}} : fe_status;
    end else begin : g_nopad
      assign stat_word = is_mb ? mb_flags[FLAG_W-1 -: DATA_W] : fe_status;
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    case (fr.off)
      OFF_CTRL: rd_data = ctrl_q;
      OFF_STAT: rd_data = stat_word;
      OFF_MASK: rd_data = is_mb ? '0 : mask_q;
      OFF_CFG:  rd_data = is_mb ? '0 : cfg_last;
      default:  rd_data = '0;
    endcase
  end

  assign rsp_load = commit && !fr.wr && hit_own;
  assign rsp_word = {1'b0, fr.addr, fr.off, {GAP_W{1'b0}}, rd_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      if (fr.off == OFF_CTRL)           ctrl_q <= fr.data;
      if (fr.off == OFF_MASK && !is_mb) mask_q <= fr.data;
    end
  end

  // One-entry stream slot: a slot draining this edge counts as free.
  assign slot_free = !cfg_valid || cfg_ready;
  assign cfg_take  = wr_en && (fr.off == OFF_CFG) && !is_mb && slot_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_valid <= 1'b0;
      cfg_data  <= '0;
      cfg_last  <= '0;
    end else if (cfg_take) begin
      cfg_valid <= 1'b1;
      cfg_data  <= fr.data;
      cfg_last  <= fr.data;
    end else if (cfg_valid && cfg_ready) begin
      cfg_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_resp_tx.sv
module spi_resp_tx
  import spi_dec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_fall,
  input  logic               cs_rise,
  input  logic               sclk_fall,
  input  logic               rsp_load,
  input  logic [FRAME_W-1:0] rsp_word,
  output logic               miso,
  output logic               miso_oe
);

  logic               pend;
  logic [FRAME_W-1:0] word_q, tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      word_q  <= '0;
      tx_sh   <= '0;
      miso_oe <= 1'b0;
    end else if (cs_rise) begin
      pend    <= rsp_load;
      word_q  <= rsp_word;
      miso_oe <= 1'b0;
    end else if (cs_fall) begin
      if (pend) begin
        tx_sh   <= word_q;
        miso_oe <= 1'b1;
      end
      pend <= 1'b0;
    end else if (sclk_fall && miso_oe) begin
      tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
    end
  end

  assign miso = miso_oe & tx_sh[FRAME_W-1];

endmodule

// File: rtl/spi_node_decoder.sv
module spi_node_decoder
  import spi_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] node_id,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic [FLAG_W-1:0] mb_flags,
  input  logic [DATA_W-1:0] fe_status,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] mask_q,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic [DATA_W-1:0] cfg_data
);

  logic [FRAME_W-1:0] frame_w, rsp_word;
  logic               commit, cs_fall, cs_rise, sclk_fall, rsp_load;

  spi_frame_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (spi_sclk),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi),
    .frame_q   (frame_w),
    .commit    (commit),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .sclk_fall (sclk_fall)
  );

  spi_reg_bank u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .frame_w   (frame_w),
    .node_id   (node_id),
    .mb_flags  (mb_flags),
    .fe_status (fe_status),
    .cfg_ready (cfg_ready),
    .ctrl_q    (ctrl_q),
    .mask_q    (mask_q),
    .cfg_valid (cfg_valid),
    .cfg_data  (cfg_data),
    .rsp_load  (rsp_load),
    .rsp_word  (rsp_word)
  );

  spi_resp_tx u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .sclk_fall (sclk_fall),
    .rsp_load  (rsp_load),
    .rsp_word  (rsp_word),
    .miso      (spi_miso),
    .miso_oe   (spi_miso_oe)
  );

endmodule

// File: rtl/spi_node_decoder_chk.sv
module spi_node_decoder_chk
  import spi_dec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] node_id,
  input logic              spi_cs_n,
  input logic              spi_miso,
  input logic              spi_miso_oe,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] mask_q,
  input logic              cfg_valid,
  input logic              cfg_ready,
  input logic [DATA_W-1:0] cfg_data
);

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_data))); // R8

  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_miso_oe |-> !spi_miso); // R6

  AST_OE_DROP_ON_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_miso_oe) |-> $past(spi_cs_n, 2)); // R6

  AST_CTRL_ONLY_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> $past(spi_cs_n, 2)); // R1

  AST_MB_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (node_id == MB_ADDR) |-> (mask_q == '0)); // R4

endmodule

bind spi_node_decoder spi_node_decoder_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .node_id     (node_id),
  .spi_cs_n    (spi_cs_n),
  .spi_miso    (spi_miso),
  .spi_miso_oe (spi_miso_oe),
  .ctrl_q      (ctrl_q),
  .mask_q      (mask_q),
  .cfg_valid   (cfg_valid),
  .cfg_ready   (cfg_ready),
  .cfg_data    (cfg_data)
);

// File: tb/test_spi_node_decoder.sv
module test_spi_node_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  node_id = 5'd7;
  logic        spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic        spi_miso, spi_miso_oe;
  logic [4:0]  mb_flags = 5'b10110;
  logic [15:0] fe_status = 16'hA5C3;
  logic [15:0] ctrl_q, mask_q, cfg_data;
  logic        cfg_valid, cfg_ready = 1'b0;

  int checks = 0, errors = 0, cycles = 0;

  // model state
  logic [15:0] m_ctrl, m_mask, m_cfg_data, m_cfg_last;
  logic        m_cfg_full, m_pend;
  logic [31:0] m_rsp;

  always #10 clk = ~clk;

  spi_node_decoder i_spi_node_decoder (
    .clk(clk), .rst_n(rst_n), .node_id(node_id),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .mb_flags(mb_flags), .fe_status(fe_status),
    .ctrl_q(ctrl_q), .mask_q(mask_q),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] mk(input logic wr, input logic [4:0] a,
                                     input logic [4:0] o, input logic [15:0] d);
    return {wr, a, o, 5'b0, d};
  endfunction

  function automatic logic [15:0] stat_val();
    return (node_id == 5'd0) ? {mb_flags, 11'b0} : fe_status;
  endfunction

  task automatic do_reset(input logic [4:0] id);
    rst_n = 1'b0;
    node_id = id;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    m_ctrl = '0; m_mask = '0; m_cfg_data = '0; m_cfg_last = '0;
    m_cfg_full = 1'b0; m_pend = 1'b0; m_rsp = '0;
  endtask

  // Shift one chip-select window; optional pulse of cfg_ready at the commit edge.
  task automatic shift(input logic [31:0] w, input int nbits, input logic collide,
                       output logic [31:0] rx, output logic oe_seen);
    rx = '0;
    oe_seen = 1'b0;
    @(negedge clk);
    spi_cs_n = 1'b0;
    wait_clk(8);
    for (int b = 0; b < nbits; b++) begin
      spi_mosi = (b < 32) ? w[31-b] : 1'b0;
      wait_clk(4);
      rx = {rx[30:0], spi_miso};
      if (b == 0) oe_seen = spi_miso_oe;
      spi_sclk = 1'b1;
      wait_clk(4);
      spi_sclk = 1'b0;
    end
    wait_clk(4);
    spi_cs_n = 1'b1;
    if (collide) begin
      @(posedge clk); @(posedge clk);
      @(negedge clk); cfg_ready = 1'b1;
      @(posedge clk);
      @(negedge clk); cfg_ready = 1'b0;
    end
    wait_clk(10);
  endtask

  // Run one frame against the model and check every output.
  task automatic frame(input string req, input logic [31:0] w, input int nbits,
                       input logic collide);
    logic [31:0] rx;
    logic        oe_seen, own, bc, fe, was_pend;
    logic [31:0] was_rsp;
    logic [4:0]  a, o;
    logic [15:0] d, rd;
    was_pend = m_pend;
    was_rsp  = m_rsp;
    shift(w, nbits, collide, rx, oe_seen);
    a = w[30:26]; o = w[25:21]; d = w[15:0];
    fe  = (node_id != 5'd0) && (node_id <= 5'd25);
    own = (a == node_id);
    bc  = (a == 5'd31) && fe;
    m_pend = 1'b0;
    if (collide && m_cfg_full) m_cfg_full = 1'b0;
    if (nbits == 32) begin
      if (w[31] && (own || bc)) begin
        if (o == 5'd0) m_ctrl = d;
        if (o == 5'd2 && node_id != 0) m_mask = d;
        if (o == 5'd3 && node_id != 0 && !m_cfg_full) begin
          m_cfg_full = 1'b1; m_cfg_data = d; m_cfg_last = d;
        end
      end else if (!w[31] && own) begin
        case (o)
          5'd0: rd = m_ctrl;
          5'd1: rd = stat_val();
          5'd2: rd = (node_id != 0) ? m_mask : 16'h0;
          5'd3: rd = (node_id != 0) ? m_cfg_last : 16'h0;
          default: rd = 16'h0;
        endcase
        m_pend = 1'b1;
        m_rsp  = {1'b0, a, o, 5'b0, rd};
      end
      chk({req, " R6 miso word"}, rx, was_pend ? was_rsp : 32'h0);
      chk({req, " R6 miso oe"}, {31'b0, oe_seen}, {31'b0, was_pend});
    end
    chk({req, " R9 ctrl"}, {16'h0, ctrl_q}, {16'h0, m_ctrl});
    chk({req, " R9 mask"}, {16'h0, mask_q}, {16'h0, m_mask});
    chk({req, " R8 cfg_valid"}, {31'b0, cfg_valid}, {31'b0, m_cfg_full});
    if (m_cfg_full) chk({req, " R8 cfg_data"}, {16'h0, cfg_data}, {16'h0, m_cfg_data});
  endtask

  logic [4:0]  ra, ro;
  logic [31:0] rw;

  initial begin
    void'($urandom(32'd4242));
    do_reset(5'd7);
    chk("R10 ctrl reset", {16'h0, ctrl_q}, 32'h0);
    chk("R10 mask reset", {16'h0, mask_q}, 32'h0);
    chk("R10 cfg_valid reset", {31'b0, cfg_valid}, 32'h0);
    chk("R10 oe reset", {30'b0, spi_miso_oe, spi_miso}, 32'h0);

    // R2/R9 own write, unused bits set; R6 read back in next window
    frame("R2 write ctrl", mk(1, 5'd7, 5'd0, 16'h1234) | 32'h001F_0000, 32, 0);
    frame("R6 read ctrl", mk(0, 5'd7, 5'd0, 16'hFFFF), 32, 0);
    frame("R5 write status ignored", mk(1, 5'd7, 5'd1, 16'h0F0F), 32, 0);
    frame("R5 read status", mk(0, 5'd7, 5'd1, 16'h0), 32, 0);
    frame("R4 write offset 9 ignored", mk(1, 5'd7, 5'd9, 16'hBEEF), 32, 0);
    frame("R4 read offset 9", mk(0, 5'd7, 5'd9, 16'h0), 32, 0);
    frame("R3 bcast write mask", mk(1, 5'd31, 5'd2, 16'h5A5A), 32, 0);
    frame("R7 bcast read", mk(0, 5'd31, 5'd0, 16'h0), 32, 0);
    frame("R7 no response window", mk(1, 5'd3, 5'd0, 16'h7777), 32, 0);
    frame("R1 short frame ignored", mk(1, 5'd7, 5'd0, 16'hDEAD), 31, 0);
    frame("R1 long frame ignored", mk(1, 5'd7, 5'd0, 16'hDEAD), 33, 0);
    // R8 stream slot
    frame("R8 cfg write", mk(1, 5'd7, 5'd3, 16'hC0DE), 32, 0);
    frame("R8 cfg write dropped", mk(1, 5'd7, 5'd3, 16'h1111), 32, 0);
    frame("R8 read cfg last", mk(0, 5'd7, 5'd3, 16'h0), 32, 0);
    frame("R8 collide accept", mk(1, 5'd7, 5'd3, 16'h2222), 32, 1);
    frame("R8 read cfg after collide", mk(0, 5'd7, 5'd3, 16'h0), 32, 0);
    frame("R8 drain", mk(0, 5'd2, 5'd0, 16'h0), 32, 1);

    for (int n = 0; n < 140; n++) begin
      case ($urandom % 4)
        0, 3: ra = node_id;
        1: ra = 5'd31;
        default: ra = 5'($urandom);
      endcase
      ro = 5'($urandom % 6);
      rw = {1'($urandom), ra, ro, 5'($urandom), 16'($urandom)};
      frame("R3 random fe", rw, 32, (n % 17) == 16);
    end

    // motherboard role
    do_reset(5'd0);
    frame("R4 mb mask write ignored", mk(1, 5'd0, 5'd2, 16'h3C3C), 32, 0);
    frame("R4 mb read mask", mk(0, 5'd0, 5'd2, 16'h0), 32, 0);
    frame("R5 mb read status", mk(0, 5'd0, 5'd1, 16'h0), 32, 0);
    frame("R3 mb ignores bcast", mk(1, 5'd31, 5'd0, 16'h9999), 32, 0);
    frame("R4 mb cfg write ignored", mk(1, 5'd0, 5'd3, 16'h4444), 32, 0);
    for (int n = 0; n < 50; n++) begin
      mb_flags = 5'($urandom);
      ra = ($urandom % 2 == 0) ? 5'd0 : 5'($urandom);
      ro = 5'($urandom % 5);
      rw = {1'($urandom), ra, ro, 5'($urandom), 16'($urandom)};
      frame("R5 random mb", rw, 32, 0);
    end
    frame("R6 final flush", mk(0, 5'd9, 5'd0, 16'h0), 32, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule